// File: doc/BRIEF.md
# Program ROM Bank Switching Unit

This block sits between a console CPU and a cartridge program ROM. The ROM is divided into 8 KB banks, and the number of banks is a parameter. The CPU sends synchronous writes to load four 8-bit bank registers and one control byte. For every CPU address, the unit combinationally produces a ROM address and a select line. The address is formed from a bank number for the current 8 KB window and the low 13 address bits.

The control byte chooses one of four banking modes. These modes act as the states of a small machine:

- FIXED: the reset state.
- PAIR
- DIRECT
- REVERSED

Any write to the control address is a transition into the mode held in data bits 1:0. Reset returns the machine to FIXED. Two further control bits are captured with the mode:

- One lets the top window at 0xE000 follow a register.
- One opens an extra window at 0x6000–0x7FFF. This window only takes effect in DIRECT mode while the top window is fixed.

Top module: `prg_bank_mapper`

## Requirements
- R1: On reset, bank register k (k = 0..3) holds N-4+k, the mode is FIXED (code 0), and both control flags are clear.
- R2: A write whose address ANDed with 0xF007 equals 0x8000+k, for k in 0..3, loads register k with the data byte. Writes to any other address leave the registers unchanged; this includes masked 0x8004 and 0x9000.
- R3: A write whose address ANDed with 0xF007 equals 0xD000 sets the following from the data byte:
  - bits 1:0 set the mode: 0 FIXED, 1 PAIR, 2 DIRECT, 3 REVERSED.
  - bit 2 sets the top-window-from-register flag.
  - bit 7 sets the 0x6000 window enable.
  A write to masked 0xD001 changes none of them.
- R4: In FIXED mode, the windows at 0x8000, 0xA000, 0xC000 and 0xE000 map banks N-4, N-3, N-2 and N-1, whatever the registers hold.
- R5: In PAIR mode, 0x8000 maps 2×reg1 and 0xA000 maps 2×reg1+1. 0xC000 maps N-2 and 0xE000 maps N-1.
- R6: In DIRECT mode with the top-window flag set, window k maps register k.
- R7: In DIRECT mode with the top-window flag clear, windows 0..2 map registers 0..2 and 0xE000 maps N-1.
- R8: In DIRECT mode with the top-window flag clear and the enable set, 0x6000–0x7FFF maps register 3. In every other case that range is not selected.
- R9: In REVERSED mode, the windows at 0x8000, 0xA000, 0xC000 and 0xE000 map registers 3, 2, 1 and 0 respectively.
- R10: Every bank number is reduced modulo N before it is used.
- R11: When selected, rom_addr is the bank number in the upper bits and cpu_addr[12:0] in the low 13 bits.
- R12: rom_sel is high for 0x8000–0xFFFF, and for 0x6000–0x7FFF only when R8 opens that window. Whenever rom_sel is low, rom_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising clock edge |
| rom_addr | output | $clog2(N)+13 | Program ROM byte address |
| rom_sel | output | 1 | ROM access select |

## Verification
The checker treats cpu_addr as stable and meaningful in every cycle, even without a write, because the mapping outputs are purely combinational. It also assumes N is at least 4 so that the fixed banks exist. It assumes that a control write in one cycle governs the mapping from the next cycle on. The stimulus changes addresses and strobes only on falling edges, holds each write strobe for exactly one rising edge, and keeps N at 24. Using 24, which is not a power of two, makes the modulo reduction visible rather than a plain truncation.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED    = 2'd0,
        MODE_PAIR     = 2'd1,
        MODE_DIRECT   = 2'd2,
        MODE_REVERSED = 2'd3
    } prg_mode_e;

    localparam int WIN_BITS   = 13;
    localparam int NUM_WIN    = 4;
    localparam int REG_W      = 8;

    localparam logic [3:0] REG_PAGE  = 4'h8;
    localparam logic [3:0] CTRL_PAGE = 4'hD;

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_map_pkg::*;
(
    input  logic         we,
    input  logic [3:0]   page,
    input  logic [2:0]   sub,
    output logic [NUM_WIN-1:0] reg_we,
    output logic         ctrl_we
);

    logic reg_page_hit;

    assign reg_page_hit = we && (page == REG_PAGE) && !sub[2];
    assign ctrl_we      = we && (page == CTRL_PAGE) && (sub == 3'd0);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_sel
        assign reg_we[k] = reg_page_hit && (sub[1:0] == 2'(k));
    end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_map_pkg::*;
#(
    parameter int ROM_BANKS = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WIN-1:0]            reg_we,
    input  logic [REG_W-1:0]              wdata,
    output logic [NUM_WIN-1:0][REG_W-1:0] regs
);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_reg
        localparam logic [REG_W-1:0] INIT = REG_W'(ROM_BANKS - NUM_WIN + k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[k] <= INIT;
            else if (reg_we[k])
                regs[k] <= wdata;
        end
    end

endmodule

// File: rtl/prg_mode_ctrl.sv
module prg_mode_ctrl
    import prg_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [1:0] mode_bits,
    input  logic       top_bit,
    input  logic       low_bit,
    output prg_mode_e  mode,
    output logic       top_from_reg,
    output logic       low_win_en
);

    prg_mode_e state_q, state_d;
    logic      top_q, low_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_FIXED;
            top_q   <= 1'b0;
            low_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_we) begin
                top_q <= top_bit;
                low_q <= low_bit;
            end
        end
    end

    // next state: any control write jumps to the mode it names
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            unique case (mode_bits)
                2'd0: state_d = MODE_FIXED;
                2'd1: state_d = MODE_PAIR;
                2'd2: state_d = MODE_DIRECT;
                2'd3: state_d = MODE_REVERSED;
            endcase
        end
    end

    // outputs
    always_comb begin
        mode         = state_q;
        top_from_reg = top_q;
        low_win_en   = low_q;
    end

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_map_pkg::*;
#(
    parameter int ROM_BANKS = 24,
    localparam int BANK_W   = $clog2(ROM_BANKS),
    localparam int ROM_AW   = BANK_W + WIN_BITS
) (
    input  prg_mode_e                     mode,
    input  logic                          top_from_reg,
    input  logic                          low_win_en,
    input  logic [NUM_WIN-1:0][REG_W-1:0] regs,
    input  logic [15:0]                   cpu_addr,
    output logic [ROM_AW-1:0]             rom_addr,
    output logic                          rom_sel
);

    function automatic logic [BANK_W-1:0] wrap(input logic [REG_W:0] raw);
        return BANK_W'(int'(raw) % ROM_BANKS);
    endfunction

    logic [NUM_WIN-1:0][BANK_W-1:0] win_bank;
    logic [BANK_W-1:0]              low_bank;
    logic                           low_open;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [REG_W:0] FIXED_BANK = (REG_W+1)'(ROM_BANKS - NUM_WIN + w);
        localparam logic [REG_W:0] LAST_BANK  = (REG_W+1)'(ROM_BANKS - 1);
        logic [REG_W:0] raw;
        always_comb begin
            unique case (mode)
                MODE_FIXED:    raw = FIXED_BANK;
                MODE_PAIR: begin
                    if (w < 2) raw = {regs[1], 1'(w)};
                    else       raw = FIXED_BANK;
                end
                MODE_DIRECT: begin
                    if (w == NUM_WIN - 1 && !top_from_reg) raw = LAST_BANK;
                    else                                   raw = {1'b0, regs[w]};
                end
                MODE_REVERSED: raw = {1'b0, regs[NUM_WIN-1-w]};
            endcase
        end
        assign win_bank[w] = wrap(raw);
    end

    assign low_bank = wrap({1'b0, regs[NUM_WIN-1]});
    assign low_open = (mode == MODE_DIRECT) && !top_from_reg && low_win_en;

    always_comb begin
        rom_sel  = 1'b0;
        rom_addr = '0;
        if (cpu_addr[15]) begin
            rom_sel  = 1'b1;
            rom_addr = {win_bank[cpu_addr[14:13]], cpu_addr[WIN_BITS-1:0]};
        end else if (cpu_addr[14:13] == 2'b11 && low_open) begin
            rom_sel  = 1'b1;
            rom_addr = {low_bank, cpu_addr[WIN_BITS-1:0]};
        end
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int ROM_BANKS = 24,
    localparam int BANK_W   = $clog2(ROM_BANKS),
    localparam int ROM_AW   = BANK_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel
);

    logic [NUM_WIN-1:0]            reg_we;
    logic                          ctrl_we;
    logic [NUM_WIN-1:0][REG_W-1:0] regs;
    prg_mode_e                     mode_q;
    logic                          top_from_reg;
    logic                          low_win_en;

    prg_wr_decode i_dec (
        .we      (cpu_we),
        .page    (cpu_addr[15:12]),
        .sub     (cpu_addr[2:0]),
        .reg_we  (reg_we),
        .ctrl_we (ctrl_we)
    );

    prg_bank_regs #(.ROM_BANKS(ROM_BANKS)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_we (reg_we),
        .wdata  (cpu_wdata),
        .regs   (regs)
    );

    prg_mode_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .mode_bits    (cpu_wdata[1:0]),
        .top_bit      (cpu_wdata[2]),
        .low_bit      (cpu_wdata[7]),
        .mode         (mode_q),
        .top_from_reg (top_from_reg),
        .low_win_en   (low_win_en)
    );

    prg_window_map #(.ROM_BANKS(ROM_BANKS)) i_map (
        .mode         (mode_q),
        .top_from_reg (top_from_reg),
        .low_win_en   (low_win_en),
        .regs         (regs),
        .cpu_addr     (cpu_addr),
        .rom_addr     (rom_addr),
        .rom_sel      (rom_sel)
    );

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
    parameter int ROM_BANKS = 24,
    localparam int BANK_W   = $clog2(ROM_BANKS),
    localparam int ROM_AW   = BANK_W + 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_we,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_sel,
    input logic [1:0]        mode_q
);

    logic ctrl_hit;
    assign ctrl_hit = cpu_we && (cpu_addr[15:12] == 4'hD) && (cpu_addr[2:0] == 3'd0);

    AST_UPPER_HALF_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> rom_sel); // R12

    AST_LOW_RANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] < 3'd3) |-> (!rom_sel && rom_addr == '0)); // R12

    AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr[12:0] == cpu_addr[12:0])); // R11

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (int'(rom_addr[ROM_AW-1:13]) < ROM_BANKS)); // R10

    AST_FIXED_MODE_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && cpu_addr[15])
        |-> (int'(rom_addr[ROM_AW-1:13]) == ROM_BANKS - 4 + int'(cpu_addr[14:13]))); // R4

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_hit |=> $stable(mode_q)); // R3

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.ROM_BANKS(ROM_BANKS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .rom_addr (rom_addr),
    .rom_sel  (rom_sel),
    .mode_q   (mode_q)
);

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;

    localparam int N      = 24;
    localparam int BW     = 5;
    localparam int AW     = BW + 13;
    localparam int NVEC   = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] rom_addr;
    logic          rom_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prg_bank_mapper #(.ROM_BANKS(N)) i_prg_bank_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .rom_addr  (rom_addr),
        .rom_sel   (rom_sel)
    );

    // {we, addr, data, expected sel, expected bank}
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b0, 16'h8000, 8'd0,    1'b1, 5'd20}, // R1 R4
        {1'b0, 16'hA123, 8'd0,    1'b1, 5'd21}, // R4 R11
        {1'b0, 16'hC000, 8'd0,    1'b1, 5'd22}, // R4
        {1'b0, 16'hFFFF, 8'd0,    1'b1, 5'd23}, // R4
        {1'b0, 16'h6000, 8'd0,    1'b0, 5'd0},  // R12
        {1'b1, 16'h8000, 8'd5,    1'b0, 5'd0},  // R2
        {1'b1, 16'h8001, 8'd13,   1'b0, 5'd0},  // R2
        {1'b1, 16'h8FF2, 8'd7,    1'b0, 5'd0},  // R2 masked
        {1'b1, 16'h8003, 8'd30,   1'b0, 5'd0},  // R2
        {1'b1, 16'h8004, 8'd17,   1'b0, 5'd0},  // R2 ignored
        {1'b0, 16'h8000, 8'd0,    1'b1, 5'd20}, // R4 regs ignored
        {1'b1, 16'hD000, 8'h01,   1'b0, 5'd0},  // R3 -> PAIR
        {1'b0, 16'h8000, 8'd0,    1'b1, 5'd2},  // R5 R10 26%24
        {1'b0, 16'hBFFF, 8'd0,    1'b1, 5'd3},  // R5 R10
        {1'b0, 16'hC000, 8'd0,    1'b1, 5'd22}, // R5
        {1'b0, 16'hE000, 8'd0,    1'b1, 5'd23}, // R5
        {1'b1, 16'hD000, 8'h02,   1'b0, 5'd0},  // R3 -> DIRECT
        {1'b0, 16'h8000, 8'd0,    1'b1, 5'd5},  // R7
        {1'b0, 16'hA000, 8'd0,    1'b1, 5'd13}, // R7
        {1'b0, 16'hC000, 8'd0,    1'b1, 5'd7},  // R7
        {1'b0, 16'hE000, 8'd0,    1'b1, 5'd23}, // R7
        {1'b0, 16'h6000, 8'd0,    1'b0, 5'd0},  // R8 enable clear
        {1'b1, 16'hD000, 8'h82,   1'b0, 5'd0},  // R3 enable
        {1'b0, 16'h7ABC, 8'd0,    1'b1, 5'd6},  // R8 R10 R11
        {1'b1, 16'hD000, 8'h86,   1'b0, 5'd0},  // R3 top flag
        {1'b0, 16'hE000, 8'd0,    1'b1, 5'd6},  // R6
        {1'b0, 16'h6000, 8'd0,    1'b0, 5'd0},  // R8 flag closes window
        {1'b1, 16'hD000, 8'h03,   1'b0, 5'd0},  // R3 -> REVERSED
        {1'b0, 16'h8000, 8'd0,    1'b1, 5'd6},  // R9
        {1'b0, 16'hA000, 8'd0,    1'b1, 5'd7},  // R9
        {1'b0, 16'hC000, 8'd0,    1'b1, 5'd13}, // R9
        {1'b0, 16'hE000, 8'd0,    1'b1, 5'd5},  // R9
        {1'b1, 16'h9000, 8'd9,    1'b0, 5'd0},  // R2 ignored
        {1'b1, 16'hD001, 8'h00,   1'b0, 5'd0},  // R3 ignored
        {1'b0, 16'hE000, 8'd0,    1'b1, 5'd5},  // R2 R3 unchanged
        {1'b0, 16'h4000, 8'd0,    1'b0, 5'd0}   // R12
    };

    task automatic expect_map(input logic [15:0] a, input logic sel, input logic [BW-1:0] bank,
                              input string req);
        logic [AW-1:0] exp_addr;
        exp_addr = sel ? {bank, a[12:0]} : '0;
        checks++;
        if (rom_sel !== sel || rom_addr !== exp_addr) begin
            errors++;
            $display("FAIL %s addr=%h sel=%b rom=%h expected sel=%b rom=%h",
                     req, a, rom_sel, rom_addr, sel, exp_addr);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic sel, input logic [BW-1:0] bank,
                           input string req);
        @(negedge clk);
        cpu_addr = a;
        #2;
        expect_map(a, sel, bank, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][30])
                do_write(VEC[i][29:14], VEC[i][13:6]);
            else
                do_read(VEC[i][29:14], VEC[i][5], VEC[i][4:0], "R-table");
        end

        // R1: reset mid-run restores registers and mode
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(16'hE000, 1'b1, 5'd23, "R1 mode back to fixed");
        do_write(16'hD000, 8'h06);
        do_read(16'h8000, 1'b1, 5'd20, "R1 reg0");
        do_read(16'hA000, 1'b1, 5'd21, "R1 reg1");
        do_read(16'hC000, 1'b1, 5'd22, "R1 reg2");
        do_read(16'hE000, 1'b1, 5'd23, "R1 reg3");
        // R5 R10: reset reg1=21, pair -> 42%24=18, 19
        do_write(16'hD000, 8'h01);
        do_read(16'h8000, 1'b1, 5'd18, "R5 R10 pair low");
        do_read(16'hA000, 1'b1, 5'd19, "R5 R10 pair high");
        // R8: window needs DIRECT mode, enable in PAIR has no effect
        do_write(16'hD000, 8'h81);
        do_read(16'h6000, 1'b0, 5'd0, "R8 pair mode");
        // R2: write strobe low changes nothing
        @(negedge clk); cpu_addr = 16'h8001; cpu_wdata = 8'd0;
        @(negedge clk);
        do_read(16'h8000, 1'b1, 5'd18, "R2 no strobe");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule